// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between an integer core's execute stage and a 32-bit data memory port that is addressed by word. For each accepted load or store instruction it forms the effective byte address from the base register value and the instruction's immediate, and issues a registered memory request. Stores get a per-byte write mask and their source data copied onto the byte lanes the mask selects. Accesses that do not fit inside their natural alignment are flagged and produce no lane enables.

For loads, the block remembers the width, extension mode and low address bits of the last request. It turns the 32-bit word the memory returns into a register value by picking the addressed byte or halfword and widening it with either sign or zero fill. Instructions that are not loads or stores, and load or store encodings with undefined width codes, are ignored.

Top module: `mem_lane_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_valid` is 0, `req_byte_en` is 0 and `load_value` is 0.
- R2: A load (opcode 7'b0000011) or store (opcode 7'b0100011) that is presented with `in_valid` gives `req_valid` = 1 on the following cycle only. Any other opcode, a load width code of 011, 110 or 111, or a store width code above 010 gives no request.
- R3: `req_addr` is `rs1_val` plus the sign-extended 12-bit immediate. For loads the immediate is instr[31:20]. For stores it is {instr[31:25], instr[11:7]}. `req_dest` is instr[11:7] for loads and 0 for stores.
- R4: A store sets `req_write` = 1. Width code 000 (byte) gives the mask 4'b0001 shifted left by addr[1:0]. Width code 001 (halfword) gives 4'b0011 shifted left by addr[1:0]. Width code 010 (word) gives 4'b1111. Lanes are little-endian, so bit k of the mask covers data bits 8k+7..8k.
- R5: Store data is the low byte of `rs2_val` copied into all four lanes for byte stores, the low halfword copied into both halves for halfword stores, and all of `rs2_val` for word stores.
- R6: A load sets `req_write` = 0 and drives `req_byte_en` with the lanes it reads, using the same mask shapes as stores.
- R7: Load codes 000 (byte) and 001 (halfword) take the lane at addr[1:0] (halfword: addr[1]) from `mem_rdata` and sign-extend it. Code 010 returns the whole word.
- R8: Load codes 100 (byte) and 101 (halfword) take the same lanes and zero-extend them.
- R9: A halfword access with addr[0] = 1, or a word access with addr[1:0] != 0, sets `req_misaligned`, gives `req_byte_en` = 0 and keeps `load_value` at 0.
- R10: `load_value` follows `mem_rdata` combinationally, using the most recent accepted load. It keeps doing so after `req_valid` falls, and it is 0 once a store has been accepted.
- R11: Instruction 0x00462683 with `rs1_val` = B gives address B+4, destination 13, a word load with mask 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory for the last load |
| req_valid | output | 1 | Memory request issued this cycle |
| req_write | output | 1 | 1 for store, 0 for load |
| req_addr | output | 32 | Effective byte address |
| req_byte_en | output | 4 | Byte lanes touched |
| req_wdata | output | 32 | Lane-steered store data |
| req_misaligned | output | 1 | Access breaks natural alignment |
| req_dest | output | 5 | Load destination register index |
| load_value | output | 32 | Extended load result |

## Verification
Request fields come from a single register stage. They are due on the cycle after `in_valid` is sampled and are gone again one cycle later. The bench drives inputs on falling edges and reads the request just after the next falling edge. It then reads again one cycle later to confirm the pulse has dropped. `load_value` has no register between `mem_rdata` and the output, so the bench changes `mem_rdata` while a request is held and samples a few nanoseconds later, with no clock edge between.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int XLEN   = 32;
    localparam int NBYTES = XLEN / 8;
    localparam int OFFW   = $clog2(NBYTES);
    localparam int IMMW   = 12;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic            is_mem;
        logic            is_store;
        acc_size_e       size;
        logic            sign_ext;
        logic [4:0]      dest;
        logic [XLEN-1:0] imm;
    } mem_op_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic is_misaligned(input acc_size_e sz, input logic [OFFW-1:0] off);
        case (sz)
            SZ_HALF: return off[0];
            SZ_WORD: return |off;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
    import lsa_pkg::*;
(
    input  logic [31:0] instr,
    output mem_op_t     op
);
    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];

    always_comb begin
        op          = '0;
        op.size     = SZ_BYTE;
        if (opc == OPC_LOAD) begin
            op.imm  = sext_imm(instr[31:20]);
            op.dest = instr[11:7];
            case (f3)
                3'b000: begin op.is_mem = 1'b1; op.size = SZ_BYTE; op.sign_ext = 1'b1; end
                3'b001: begin op.is_mem = 1'b1; op.size = SZ_HALF; op.sign_ext = 1'b1; end
                3'b010: begin op.is_mem = 1'b1; op.size = SZ_WORD; op.sign_ext = 1'b0; end
                3'b100: begin op.is_mem = 1'b1; op.size = SZ_BYTE; op.sign_ext = 1'b0; end
                3'b101: begin op.is_mem = 1'b1; op.size = SZ_HALF; op.sign_ext = 1'b0; end
                default: op.is_mem = 1'b0;
            endcase
        end else if (opc == OPC_STORE) begin
            op.imm      = sext_imm({instr[31:25], instr[11:7]});
            op.is_store = 1'b1;
            case (f3)
                3'b000: begin op.is_mem = 1'b1; op.size = SZ_BYTE; end
                3'b001: begin op.is_mem = 1'b1; op.size = SZ_HALF; end
                3'b010: begin op.is_mem = 1'b1; op.size = SZ_WORD; end
                default: op.is_mem = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lsa_lane_gen.sv
module lsa_lane_gen
    import lsa_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFFW-1:0]   off,
    input  logic [XLEN-1:0]   src,
    output logic [NBYTES-1:0] byte_en,
    output logic [XLEN-1:0]   lane_data,
    output logic              misaligned
);
    assign misaligned = is_misaligned(size, off);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic hit;
        always_comb begin
            case (size)
                SZ_WORD: hit = 1'b1;
                SZ_HALF: hit = (b / 2) == int'(off[OFFW-1]);
                default: hit = b == int'(off);
            endcase
        end
        assign byte_en[b] = hit & ~misaligned;

        always_comb begin
            case (size)
                SZ_WORD: lane_data[8*b +: 8] = src[8*b +: 8];
                SZ_HALF: lane_data[8*b +: 8] = src[8*(b % 2) +: 8];
                default: lane_data[8*b +: 8] = src[7:0];
            endcase
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [XLEN-1:0] rdata,
    input  acc_size_e       size,
    input  logic            sign_ext,
    input  logic [OFFW-1:0] off,
    input  logic            enable,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] shifted;

    assign shifted = rdata >> {off, 3'b000};

    always_comb begin
        value = '0;
        if (enable) begin
            case (size)
                SZ_BYTE: value = {{(XLEN-8){sign_ext & shifted[7]}}, shifted[7:0]};
                SZ_HALF: value = {{(XLEN-16){sign_ext & shifted[15]}}, shifted[15:0]};
                default: value = rdata;
            endcase
        end
    end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
    import lsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] rs1_val,
    input  logic [31:0] rs2_val,
    input  logic [31:0] mem_rdata,
    output logic        req_valid,
    output logic        req_write,
    output logic [31:0] req_addr,
    output logic [3:0]  req_byte_en,
    output logic [31:0] req_wdata,
    output logic        req_misaligned,
    output logic [4:0]  req_dest,
    output logic [31:0] load_value
);
    mem_op_t           op;
    logic [XLEN-1:0]   ea;
    logic [NBYTES-1:0] be_d;
    logic [XLEN-1:0]   wd_d;
    logic              mis_d;
    logic              accept;

    acc_size_e         size_q;
    logic              sign_q;
    logic [OFFW-1:0]   off_q;
    logic              held_ld_q;

    lsa_decode u_dec (.instr(instr), .op(op));

    assign ea     = rs1_val + op.imm;
    assign accept = in_valid & op.is_mem;

    lsa_lane_gen u_lanes (
        .size(op.size), .off(ea[OFFW-1:0]), .src(rs2_val),
        .byte_en(be_d), .lane_data(wd_d), .misaligned(mis_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid      <= 1'b0;
            req_write      <= 1'b0;
            req_addr       <= '0;
            req_byte_en    <= '0;
            req_wdata      <= '0;
            req_misaligned <= 1'b0;
            req_dest       <= '0;
            size_q         <= SZ_BYTE;
            sign_q         <= 1'b0;
            off_q          <= '0;
            held_ld_q      <= 1'b0;
        end else begin
            req_valid   <= accept;
            req_byte_en <= accept ? be_d : '0;
            if (accept) begin
                req_write      <= op.is_store;
                req_addr       <= ea;
                req_wdata      <= wd_d;
                req_misaligned <= mis_d;
                req_dest       <= op.dest;
                size_q         <= op.size;
                sign_q         <= op.sign_ext;
                off_q          <= ea[OFFW-1:0];
                held_ld_q      <= ~op.is_store;
            end
        end
    end

    lsa_load_extract u_ext (
        .rdata(mem_rdata), .size(size_q), .sign_ext(sign_q), .off(off_q),
        .enable(held_ld_q & ~req_misaligned), .value(load_value)
    );

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !req_valid);

    p_idle_no_lanes_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> req_byte_en == 4'b0000);

    p_misal_no_lanes_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_misaligned) |-> req_byte_en == 4'b0000);

    p_mask_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_misaligned) |->
            ($countones(req_byte_en) == 1 || req_byte_en == 4'b0011 ||
             req_byte_en == 4'b1100 || req_byte_en == 4'b1111));

    p_store_no_dest_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> req_dest == 5'd0);

    p_misal_zero_load_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_misaligned) |-> load_value == 32'd0);
endmodule

// File: tb/mem_lane_aligner_test.sv
module mem_lane_aligner_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0, mem_rdata = '0;
    logic        req_valid, req_write, req_misaligned;
    logic [31:0] req_addr, req_wdata, load_value;
    logic [3:0]  req_byte_en;
    logic [4:0]  req_dest;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mem_lane_aligner uut (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] enc_ld(logic [2:0] f3, logic [4:0] rd, logic [11:0] imm);
        return {imm, 5'd12, f3, rd, 7'b0000011};
    endfunction
    function automatic logic [31:0] enc_st(logic [2:0] f3, logic [11:0] imm);
        return {imm[11:5], 5'd13, 5'd12, f3, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [3:0] exp_mask(int sz, logic [1:0] off);
        if (sz == 4) return (off == 0) ? 4'b1111 : 4'b0000;
        if (sz == 2) return off[0] ? 4'b0000 : (4'b0011 << off);
        return 4'b0001 << off;
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] w, int sz, bit sgn, logic [1:0] off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*off +: 8];
        h = off[1] ? w[31:16] : w[15:0];
        if (sz == 1) return sgn ? {{24{b[7]}}, b} : {24'd0, b};
        if (sz == 2) return sgn ? {{16{h[15]}}, h} : {16'd0, h};
        return w;
    endfunction

    task automatic issue(logic [31:0] i, logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        instr = i; rs1_val = a; rs2_val = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 valid in reset", {31'd0, req_valid}, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 valid", {31'd0, req_valid}, 32'd0);
        chk("R1 mask", {28'd0, req_byte_en}, 32'd0);
        chk("R1 load_value", load_value, 32'd0);
    endtask

    task automatic t_example;
        issue(32'h00462683, 32'h0000_1000, 32'd0);
        chk("R11 valid", {31'd0, req_valid}, 32'd1);
        chk("R11 addr", req_addr, 32'h0000_1004);
        chk("R11 dest", {27'd0, req_dest}, 32'd13);
        chk("R11 mask", {28'd0, req_byte_en}, 32'hF);
        chk("R11 write", {31'd0, req_write}, 32'd0);
        @(negedge clk); #1;
        chk("R2 pulse drops", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_stores;
        for (int sz = 1; sz <= 4; sz = sz * 2) begin
            for (int o = 0; o < 4; o++) begin
                logic [2:0]  f3;
                logic [31:0] d, ew;
                f3 = (sz == 1) ? 3'b000 : (sz == 2) ? 3'b001 : 3'b010;
                d  = 32'hA1B2_C3D4;
                ew = (sz == 1) ? {4{d[7:0]}} : (sz == 2) ? {2{d[15:0]}} : d;
                issue(enc_st(f3, 12'hFF8 + 12'(o)), 32'h0000_2010, d);
                chk("R3 store addr", req_addr, 32'h0000_2008 + o);
                chk("R3 store dest", {27'd0, req_dest}, 32'd0);
                chk("R4 store write", {31'd0, req_write}, 32'd1);
                chk("R4 store mask", {28'd0, req_byte_en}, {28'd0, exp_mask(sz, 2'(o))});
                if (exp_mask(sz, 2'(o)) != 0) chk("R5 store data", req_wdata, ew);
            end
        end
        issue(enc_st(3'b001, 12'h7E1), 32'd0, 32'd0);
        chk("R3 positive split imm", req_addr, 32'h0000_07E1);
    endtask

    task automatic t_loads;
        logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
        int         szs   [5] = '{1, 2, 4, 1, 2};
        bit         sg    [5] = '{1, 1, 0, 0, 0};
        for (int k = 0; k < 5; k++) begin
            for (int o = 0; o < 4; o++) begin
                if (exp_mask(szs[k], 2'(o)) != 0) begin
                    issue(enc_ld(codes[k], 5'd7, 12'(o)), 32'h0000_3000, 32'd0);
                    chk("R6 load write", {31'd0, req_write}, 32'd0);
                    chk("R6 load mask", {28'd0, req_byte_en}, {28'd0, exp_mask(szs[k], 2'(o))});
                    chk("R3 load dest", {27'd0, req_dest}, 32'd7);
                    mem_rdata = 32'h8A7F_C501; #1;
                    chk(sg[k] ? "R7 signed load" : "R8 unsigned load", load_value,
                        exp_load(32'h8A7F_C501, szs[k], sg[k], 2'(o)));
                    mem_rdata = 32'h1280_7FEE; #1;
                    chk(sg[k] ? "R7 signed load b" : "R8 unsigned load b", load_value,
                        exp_load(32'h1280_7FEE, szs[k], sg[k], 2'(o)));
                end
            end
        end
    endtask

    task automatic t_misaligned;
        issue(enc_ld(3'b001, 5'd3, 12'd1), 32'h0000_4000, 32'd0);
        chk("R9 half misal flag", {31'd0, req_misaligned}, 32'd1);
        chk("R9 half misal mask", {28'd0, req_byte_en}, 32'd0);
        mem_rdata = 32'hFFFF_FFFF; #1;
        chk("R9 misal load value", load_value, 32'd0);
        issue(enc_st(3'b010, 12'd2), 32'h0000_4000, 32'h55);
        chk("R9 word misal flag", {31'd0, req_misaligned}, 32'd1);
        chk("R9 word misal mask", {28'd0, req_byte_en}, 32'd0);
        issue(enc_ld(3'b101, 5'd3, 12'd2), 32'h0000_4000, 32'd0);
        chk("R9 aligned half no flag", {31'd0, req_misaligned}, 32'd0);
    endtask

    task automatic t_ignored;
        logic [31:0] bad [4] = '{32'h0056_0693, enc_ld(3'b011, 5'd4, 12'd0),
                                 enc_ld(3'b110, 5'd4, 12'd0), enc_st(3'b100, 12'd0)};
        for (int k = 0; k < 4; k++) begin
            issue(bad[k], 32'h100, 32'h1);
            chk("R2 ignored valid", {31'd0, req_valid}, 32'd0);
            chk("R2 ignored mask", {28'd0, req_byte_en}, 32'd0);
        end
    endtask

    task automatic t_hold;
        issue(enc_ld(3'b000, 5'd9, 12'd3), 32'h0000_5000, 32'd0);
        @(negedge clk); #1;
        chk("R10 valid dropped", {31'd0, req_valid}, 32'd0);
        mem_rdata = 32'h8000_0000; #1;
        chk("R10 held load follows rdata", load_value, 32'hFFFF_FF80);
        mem_rdata = 32'h7F00_0000; #1;
        chk("R10 held load follows rdata b", load_value, 32'h0000_007F);
        issue(enc_st(3'b000, 12'd0), 32'h0000_5000, 32'h12);
        @(negedge clk); #1;
        chk("R10 zero after store", load_value, 32'd0);
    endtask

    initial begin
        t_reset();
        t_example();
        t_stores();
        t_loads();
        t_misaligned();
        t_ignored();
        t_hold();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule